// File: doc/BRIEF.md
# Four-Word Load Burst Splitter

This block turns a request to load four consecutive 32-bit words into one or two read-address transactions on a 64-bit bus. A requester presents a byte start address and a memory-class flag over a valid/ready handshake. The flag is set for strongly-ordered or device memory. It is clear for normal noncacheable memory, which is also the class to use when the cache is off. For each transaction the block drives an address, an incrementing burst type, a transfer size and a beat count toward the read-address channel, using its own valid/ready handshake.

The word slot inside a 32-byte line is taken from the address. The transfer size and beat count follow from three things: whether the start word is even or odd, the memory class, and how many words the transaction covers. A load whose four words would run past the end of the line is split in two. The first part runs to the end of the line and the second part restarts at the line base. The block accepts one request at a time and holds each transaction steady until the channel takes it.

Top module: `lmb_burst_split`

## Requirements
- R1: A request starting at word 0, 2 or 4 of the line, of either memory class, issues one transaction with size code 3 (8 bytes) and length code 1 (two beats), at the word address.
- R2: Every transaction carries burst code 2'b01 (incrementing).
- R3: A device-class request starting at word 1 or 3 issues one transaction with size code 2 (4 bytes) and length code 3 (four beats), at the word address.
- R4: A normal-class request starting at word 1 or 3 issues one transaction with size code 3 and length code 2 (three beats), with the address left at the unaligned word address.
- R5: A request starting at word 5, 6 or 7 (address bits [4:2] equal to 5, 6 or 7) issues two transactions. The second is at the line base, with address bits [4:0] all zero.
- R6: The split parts cover 3 then 1 words from word 5, 2 then 2 from word 6, and 1 then 3 from word 7. A one-word part uses size code 2 and length code 0. A part of two or more words from an even word uses size code 3 and a length code equal to the number of 8-byte beats minus one. A part from an odd word uses size code 2 with length code equal to words minus one for the device class, and size code 3 spanning its 8-byte beats for the normal class.
- R7: No transaction touches bytes outside the 32-byte line of its start address.
- R8: Request address bits [1:0] are ignored. Every issued address has bits [1:0] equal to zero.
- R9: While ar_valid is high and ar_ready is low, ar_valid, ar_addr, ar_size and ar_len stay unchanged.
- R10: ar_valid rises in the cycle after a request is accepted. The second part of a split follows in the cycle after the first part's handshake. req_ready stays low from acceptance until the cycle after the last handshake.
- R11: While rst is high, ar_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte start address of the four-word load |
| req_dev | input | 1 | 1 = strongly-ordered/device, 0 = normal noncacheable |
| ar_valid | output | 1 | Read-address transaction valid |
| ar_ready | input | 1 | Read-address channel accepts |
| ar_addr | output | ADDR_W | Transaction byte address |
| ar_burst | output | 2 | Burst type code |
| ar_size | output | 3 | Transfer size code (log2 bytes) |
| ar_len | output | LEN_W | Beats minus one |

## Verification
A request is accepted at the clock edge where req_valid and req_ready are both high. Its first transaction is due on the outputs just after that edge, and a second part is due just after the edge on which the first part's handshake completes. The bench drives inputs shortly after each rising edge. On every falling edge it compares the outputs against a queue of expected transactions, and only then advances that queue with the handshakes it sees, so each comparison lands in the exact cycle in which a result must be present. The ready pattern is varied (always ready, pseudo-random, long stalls) so that both holding and back-to-back parts fall on checked cycles.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [2:0] SIZE_4B    = 3'd2;
  localparam logic [2:0] SIZE_8B    = 3'd3;
  localparam int         WORD_OFS   = 2;
endpackage

// File: rtl/lmb_split_plan.sv
module lmb_split_plan #(
  parameter int LINE_WORDS = 8,
  parameter int LOAD_WORDS = 4,
  localparam int WIDX_W = $clog2(LINE_WORDS),
  localparam int CNT_W  = $clog2(LOAD_WORDS + 1)
) (
  input  logic [WIDX_W-1:0] start_word,
  output logic [CNT_W-1:0]  first_cnt,
  output logic [CNT_W-1:0]  second_cnt,
  output logic              split
);
  int room;

  always_comb begin
    room = LINE_WORDS - int'(start_word);
    if (room < LOAD_WORDS) begin
      split      = 1'b1;
      first_cnt  = CNT_W'(room);
      second_cnt = CNT_W'(LOAD_WORDS - room);
    end else begin
      split      = 1'b0;
      first_cnt  = CNT_W'(LOAD_WORDS);
      second_cnt = '0;
    end
  end
endmodule

// File: rtl/lmb_op_encode.sv
module lmb_op_encode #(
  parameter int LINE_WORDS = 8,
  parameter int LOAD_WORDS = 4,
  parameter int LEN_W      = 8,
  localparam int WIDX_W = $clog2(LINE_WORDS),
  localparam int CNT_W  = $clog2(LOAD_WORDS + 1)
) (
  input  logic [WIDX_W-1:0] start_word,
  input  logic [CNT_W-1:0]  count,
  input  logic              dev,
  output logic [2:0]        size,
  output logic [LEN_W-1:0]  len
);
  import lmb_pkg::*;

  int first_dw;
  int last_dw;

  always_comb begin
    first_dw = int'(start_word) >> 1;
    last_dw  = (int'(start_word) + int'(count) - 1) >> 1;
    if (count <= CNT_W'(1)) begin
      size = SIZE_4B;
      len  = '0;
    end else if (start_word[0] && dev) begin
      size = SIZE_4B;
      len  = LEN_W'(int'(count) - 1);
    end else begin
      size = SIZE_8B;
      len  = LEN_W'(last_dw - first_dw);
    end
  end
endmodule

// File: rtl/lmb_burst_split.sv
module lmb_burst_split #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int LOAD_WORDS = 4,
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dev,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [1:0]        ar_burst,
  output logic [2:0]        ar_size,
  output logic [LEN_W-1:0]  ar_len
);
  import lmb_pkg::*;

  localparam int WIDX_W   = $clog2(LINE_WORDS);
  localparam int LINE_OFS = WORD_OFS + WIDX_W;
  localparam int CNT_W    = $clog2(LOAD_WORDS + 1);
  localparam int PARTS    = 2;

  logic [WIDX_W-1:0] part_word [PARTS];
  logic [CNT_W-1:0]  part_cnt  [PARTS];
  logic [2:0]        part_size [PARTS];
  logic [LEN_W-1:0]  part_len  [PARTS];
  logic              split;

  logic              pend_q;
  logic [ADDR_W-1:0] sec_addr_q;
  logic [2:0]        sec_size_q;
  logic [LEN_W-1:0]  sec_len_q;

  assign part_word[0] = req_addr[LINE_OFS-1:WORD_OFS];
  assign part_word[1] = '0;

  lmb_split_plan #(
    .LINE_WORDS(LINE_WORDS),
    .LOAD_WORDS(LOAD_WORDS)
  ) u_plan (
    .start_word(part_word[0]),
    .first_cnt (part_cnt[0]),
    .second_cnt(part_cnt[1]),
    .split     (split)
  );

  for (genvar g = 0; g < PARTS; g++) begin : g_enc
    lmb_op_encode #(
      .LINE_WORDS(LINE_WORDS),
      .LOAD_WORDS(LOAD_WORDS),
      .LEN_W     (LEN_W)
    ) u_enc (
      .start_word(part_word[g]),
      .count     (part_cnt[g]),
      .dev       (req_dev),
      .size      (part_size[g]),
      .len       (part_len[g])
    );
  end

  assign req_ready = !ar_valid;
  assign ar_burst  = BURST_INCR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_valid   <= 1'b0;
      ar_addr    <= '0;
      ar_size    <= '0;
      ar_len     <= '0;
      pend_q     <= 1'b0;
      sec_addr_q <= '0;
      sec_size_q <= '0;
      sec_len_q  <= '0;
    end else if (!ar_valid) begin
      if (req_valid) begin
        ar_valid   <= 1'b1;
        ar_addr    <= {req_addr[ADDR_W-1:WORD_OFS], {WORD_OFS{1'b0}}};
        ar_size    <= part_size[0];
        ar_len     <= part_len[0];
        pend_q     <= split;
        sec_addr_q <= {req_addr[ADDR_W-1:LINE_OFS], {LINE_OFS{1'b0}}};
        sec_size_q <= part_size[1];
        sec_len_q  <= part_len[1];
      end
    end else if (ar_ready) begin
      if (pend_q) begin
        ar_addr <= sec_addr_q;
        ar_size <= sec_size_q;
        ar_len  <= sec_len_q;
        pend_q  <= 1'b0;
      end else begin
        ar_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lmb_burst_split_chk.sv
module lmb_burst_split_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int LOAD_WORDS = 4,
  parameter int LEN_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_dev,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [1:0]        ar_burst,
  input logic [2:0]        ar_size,
  input logic [LEN_W-1:0]  ar_len
);
  localparam int LINE_OFS   = 2 + $clog2(LINE_WORDS);
  localparam int LINE_BYTES = 4 * LINE_WORDS;

  int  span_start;
  int  span_bytes;
  logic span_ok;

  always_comb begin
    span_start = int'(ar_addr[LINE_OFS-1:0]) & ~((1 << ar_size) - 1);
    span_bytes = (int'(ar_len) + 1) << ar_size;
    span_ok    = (span_start + span_bytes) <= LINE_BYTES;
  end

  AST_BURST_INCR: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> ar_burst == 2'b01); // R2

  AST_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> span_ok); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_size) && $stable(ar_len)); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> !req_ready); // R10

  AST_SECOND_AT_BASE: assert property (@(posedge clk) disable iff (rst)
    $past(ar_valid && ar_ready) && ar_valid |-> ar_addr[LINE_OFS-1:0] == '0); // R5

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> ar_addr[1:0] == 2'b00); // R8
endmodule

bind lmb_burst_split lmb_burst_split_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_WORDS(LINE_WORDS),
  .LOAD_WORDS(LOAD_WORDS),
  .LEN_W     (LEN_W)
) u_chk (.*);

// File: tb/sim_lmb_burst_split.sv
module sim_lmb_burst_split;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  size;
    logic [7:0]  len;
    string       tag;
  } op_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_dev = 1'b0;
  logic        ar_valid;
  logic        ar_ready = 1'b0;
  logic [31:0] ar_addr;
  logic [1:0]  ar_burst;
  logic [2:0]  ar_size;
  logic [7:0]  ar_len;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   started  = 0;
  bit   stall_prev = 0;
  int   ready_mode = 0;
  int   cyc = 0;
  logic [7:0] lf = 8'h5a;
  op_t  q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lmb_burst_split u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dev(req_dev), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_burst(ar_burst),
    .ar_size(ar_size), .ar_len(ar_len)
  );

  function automatic void exp_enc(int w, int n, bit dev, output logic [2:0] sz, output logic [7:0] ln);
    if (n == 1) begin sz = 3'd2; ln = 8'd0; end
    else if (w % 2 == 0) begin sz = 3'd3; ln = 8'((n + 1) / 2 - 1); end
    else if (dev) begin sz = 3'd2; ln = 8'(n - 1); end
    else begin sz = 3'd3; ln = 8'(n / 2); end
  endfunction

  function automatic void push_req(logic [31:0] a, bit dev);
    op_t o;
    int  w = int'(a[4:2]);
    int  n1;
    n1 = (w <= 4) ? 4 : 8 - w;
    o.addr = {a[31:2], 2'b00};
    exp_enc(w, n1, dev, o.size, o.len);
    if (w > 4) o.tag = "R6";
    else if (w % 2 == 0) o.tag = "R1";
    else o.tag = dev ? "R3" : "R4";
    q.push_back(o);
    if (w > 4) begin
      o.addr = {a[31:5], 5'b0};
      exp_enc(0, 4 - n1, dev, o.size, o.len);
      o.tag = "R5";
      q.push_back(o);
    end
  endfunction

  always @(posedge clk) begin
    lf  <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    cyc <= cyc + 1;
    #1;
    case (ready_mode)
      0: ar_ready = 1'b1;
      1: ar_ready = lf[0] | lf[2];
      default: ar_ready = (cyc % 6 == 0);
    endcase
  end

  always @(negedge clk) begin
    if (rst) begin
      n_checks++;
      if (ar_valid !== 1'b0 || req_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL R11 reset: ar_valid=%b req_ready=%b expected 0/1", ar_valid, req_ready);
      end
    end else if (started) begin
      bit  ev;
      int  st;
      int  by;
      ev = (q.size() != 0);
      n_checks++;
      if (ar_valid !== ev || req_ready !== !ev) begin
        n_fail++;
        $display("FAIL R10 handshake: ar_valid=%b req_ready=%b expected %b/%b",
                 ar_valid, req_ready, ev, !ev);
      end else if (ev) begin
        if (ar_addr !== q[0].addr || ar_size !== q[0].size || ar_len !== q[0].len || ar_burst !== 2'b01) begin
          n_fail++;
          $display("FAIL %s addr=%h size=%0d len=%0d burst=%b expected addr=%h size=%0d len=%0d burst=01 (R2,R8)",
                   stall_prev ? "R9" : q[0].tag, ar_addr, ar_size, ar_len, ar_burst,
                   q[0].addr, q[0].size, q[0].len);
        end
        // R7: span within the 32-byte line
        n_checks++;
        st = int'(ar_addr[4:0]) & ~((1 << ar_size) - 1);
        by = (int'(ar_len) + 1) << ar_size;
        if (st + by > 32) begin
          n_fail++;
          $display("FAIL R7 span end=%0d expected <=32", st + by);
        end
      end
      stall_prev = ev && !ar_ready;
      if (ev && ar_ready) void'(q.pop_front());
      if (req_valid && !ev) push_req(req_addr, req_dev);
    end
  end

  task automatic issue(logic [31:0] a, bit dev);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    req_dev   = dev;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    started = 1;
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < 8; w++) begin
          issue({8'(16 * m + w), 19'(w * 77 + d), 3'(w), 2'(w + m)}, d[0]);
          if ((w + d) % 3 == 0) idle(2);
        end
      end
    end
    ready_mode = 1;
    for (int k = 0; k < 40; k++) issue({27'(k * 13 + 5), 5'(k * 7)}, k[1]);
    idle(60);
    if (q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R10 %0d transactions never issued, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog expired, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule